// File: doc/BRIEF.md
# System Clock Source Switch with Stability Check

This block chooses which of five candidate clocks drives the system, and divides the chosen clock by a programmable number. Each candidate (external crystal, PLL, PLL halved, low-speed oscillator near 10 kHz and internal high-speed oscillator near 22 MHz) reaches the block as a one-cycle tick on a common fast reference clock. Each candidate also has a flag that is high only when that source is enabled and settled. The system clock leaves the block as a clock-enable pulse, `sys_ce`.

Software writes a 3-bit code to ask for a new source. A request takes effect only when the target source reports stable. Otherwise the old source keeps running and a sticky fail flag is raised. Every request updates the flag, either to success or to failure. Writing 1 to the flag clears it. The readback of the select code always shows the source that is in use.

Top module: `clksw_sysclk`

## Requirements
- R1: In reset, the select readback loads 3'b111 when `boot_hirc` is 1 and 3'b000 when it is 0. In reset, `sw_fail`, `div_rd` and `sys_ce` are all 0.
- R2: Select codes map to source bits of `src_tick`/`src_stable` as follows: 000 is bit 0 (crystal), 001 is bit 1 (PLL/2), 010 is bit 2 (PLL), 011 is bit 3 (low-speed oscillator), and 111 is bit 4 (high-speed oscillator).
- R3: If a request names a source whose stable bit is 1, then from the next cycle `sel_rd` equals the written code and `sw_fail` is 0.
- R4: If a request names a source whose stable bit is 0, then `sel_rd` keeps its previous value and `sw_fail` is 1 from the next cycle.
- R5: Codes 100, 101 and 110 are always rejected. They leave `sel_rd` unchanged and set `sw_fail` to 1.
- R6: A pulse on `clr_wr` with `clr_wdata` = 1 clears `sw_fail` in the next cycle. A pulse with `clr_wdata` = 0 has no effect. If a select request arrives in the same cycle as a clear, the request decides the flag.
- R7: `sys_ce` is high for one cycle on every (N+1)-th tick of the selected source, where N is the divide number, starting from a restarted count. `sys_ce` is high in the cycle after the edge that samples that tick. Ticks of sources that are not selected have no effect.
- R8: An accepted switch, or a write of the divide number, sets the count back to zero. In that case `sys_ce` is 0 in the following cycle.
- R9: A write on `div_wr` stores `div_wdata`, and it reads back on `div_rd` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_hirc | input | 1 | Boot configuration; 1 selects the high-speed oscillator at reset |
| src_tick | input | 5 | Per-source clock-enable ticks, indexed as in R2 |
| src_stable | input | 5 | Per-source stable flags, indexed as in R2 |
| sel_wr | input | 1 | Select write strobe (switch request) |
| sel_wdata | input | 3 | Requested select code |
| div_wr | input | 1 | Divide-number write strobe |
| div_wdata | input | 4 | Divide number N |
| clr_wr | input | 1 | Fail-flag write strobe |
| clr_wdata | input | 1 | Fail-flag write data; 1 clears |
| sel_rd | output | 3 | Active select code |
| div_rd | output | 4 | Stored divide number |
| sw_fail | output | 1 | Sticky switch-fail flag |
| sys_ce | output | 1 | Divided system clock enable |

## Verification
The switch logic is tried with all eight codes against all 32 stable masks. This separates the two things that decide acceptance: whether the code is defined, and whether the named source is stable. It also catches a wrong code-to-source mapping. The divider is tried with all five sources and all sixteen divide numbers. The selected source ticks sparsely while every other source ticks on every cycle. A pulse count equal to ticks/(N+1) therefore shows that the correct source is chosen and that the divide ratio is right. Separate cases cover clearing with 0 and with 1, a clear that collides with a rejected request, and both boot configurations.

// File: rtl/clksw_pkg.sv
// Shared constants and code helpers for the system clock switch.
// Assumes five sources and a 3-bit select code with three unused values.
package clksw_pkg;
    localparam int SEL_W  = 3;
    localparam int NSRC   = 5;
    localparam int IDX_W  = $clog2(NSRC);
    localparam logic [SEL_W-1:0] CODE_XTAL = 3'b000;
    localparam logic [SEL_W-1:0] CODE_HIRC = 3'b111;

    // True for the five defined select codes.
    function automatic logic code_valid(input logic [SEL_W-1:0] c);
        return (c[2] == 1'b0) || (c == CODE_HIRC);
    endfunction

    // Maps a select code to a source bit position; undefined codes give 0.
    function automatic logic [IDX_W-1:0] code_index(input logic [SEL_W-1:0] c);
        logic [IDX_W-1:0] r;
        if (c == CODE_HIRC)  r = IDX_W'(NSRC - 1);
        else if (!c[2])      r = IDX_W'(c[1:0]);
        else                 r = '0;
        return r;
    endfunction
endpackage

// File: rtl/clksw_select.sv
// Select register and sticky fail flag. A request is accepted only when
// its code is defined and the named source is stable. Assumes requests
// and clears arrive as single-cycle strobes on clk.
module clksw_select
    import clksw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_hirc,
    input  logic [NSRC-1:0]  src_stable,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             clr_wr,
    input  logic             clr_wdata,
    output logic [SEL_W-1:0] sel_q,
    output logic             fail_q,
    output logic             accept_o
);
    logic target_ok;

    // Decide whether the requested target may become active.
    always_comb begin
        target_ok = code_valid(sel_wdata) && src_stable[code_index(sel_wdata)];
        accept_o  = sel_wr && target_ok;
    end

    // Select register: loads the boot code in reset, otherwise accepted codes.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_q <= boot_hirc ? CODE_HIRC : CODE_XTAL;
        else if (accept_o) sel_q <= sel_wdata;
    end

    // Fail flag: every request updates it; otherwise a write of 1 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                    fail_q <= 1'b0;
        else if (sel_wr)               fail_q <= !target_ok;
        else if (clr_wr && clr_wdata)  fail_q <= 1'b0;
    end

    a_r3_accept_switches: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && code_valid(sel_wdata) && src_stable[code_index(sel_wdata)])
        |=> (sel_q == $past(sel_wdata)) && !fail_q);

    a_r4_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && code_valid(sel_wdata) && !src_stable[code_index(sel_wdata)])
        |=> $stable(sel_q) && fail_q);

    a_r5_undefined_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && sel_wdata[2] && (sel_wdata != CODE_HIRC))
        |=> $stable(sel_q) && fail_q);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_wdata && !sel_wr) |=> !fail_q);

    a_r2_active_defined: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid(sel_q));
endmodule

// File: rtl/clksw_divider.sv
// Divides a tick stream by N+1 and registers the resulting enable.
// Assumes tick is already the selected source; restart zeroes the count
// and forces the enable low for the next cycle.
module clksw_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIV_W-1:0] div_n,
    input  logic             restart,
    output logic             ce_o
);
    logic [DIV_W-1:0] cnt;

    // Tick counter: wraps after N+1 ticks, zeroed on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  cnt <= '0;
        else if (tick)          cnt <= (cnt == div_n) ? '0 : cnt + 1'b1;
    end

    // Output enable: one cycle per wrap, low after a restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  ce_o <= 1'b0;
        else                    ce_o <= tick && (cnt == div_n);
    end

    a_r8_blank_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !ce_o);

    a_r7_ce_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ce_o |-> $past(tick));

    a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= div_n || $past(div_n != div_n) || $changed(div_n) || $past(restart));
endmodule

// File: rtl/clksw_sysclk.sv
// System clock switch top: guarded source selection, tick mux and
// divide-by-(N+1) enable generation. Assumes all sources are given as
// enable ticks synchronous to clk.
module clksw_sysclk
    import clksw_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_hirc,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [NSRC-1:0]  src_stable,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             clr_wr,
    input  logic             clr_wdata,
    output logic [SEL_W-1:0] sel_rd,
    output logic [DIV_W-1:0] div_rd,
    output logic             sw_fail,
    output logic             sys_ce
);
    logic             accept;
    logic             active_tick;
    logic [DIV_W-1:0] div_q;

    clksw_select u_sel (
        .clk(clk), .rst_n(rst_n), .boot_hirc(boot_hirc),
        .src_stable(src_stable), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .sel_q(sel_rd), .fail_q(sw_fail), .accept_o(accept)
    );

    // Divide-number register.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (div_wr) div_q <= div_wdata;
    end

    // Tick of the active source only.
    always_comb active_tick = src_tick[code_index(sel_rd)];

    clksw_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(active_tick), .div_n(div_q),
        .restart(accept || div_wr), .ce_o(sys_ce)
    );

    assign div_rd = div_q;

    a_r9_div_store: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> div_rd == $past(div_wdata));

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !sys_ce && !sw_fail);
endmodule

// File: tb/tb_clksw_sysclk.sv
module tb_clksw_sysclk;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boot_hirc = 1'b0;
    logic [4:0] src_tick = '0;
    logic [4:0] src_stable = '0;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_wdata = '0;
    logic       div_wr = 1'b0;
    logic [3:0] div_wdata = '0;
    logic       clr_wr = 1'b0;
    logic       clr_wdata = 1'b0;
    logic [2:0] sel_rd;
    logic [3:0] div_rd;
    logic       sw_fail;
    logic       sys_ce;

    int checks = 0;
    int fails = 0;

    clksw_sysclk dut (
        .clk(clk), .rst_n(rst_n), .boot_hirc(boot_hirc), .src_tick(src_tick),
        .src_stable(src_stable), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .div_wr(div_wr), .div_wdata(div_wdata), .clr_wr(clr_wr),
        .clr_wdata(clr_wdata), .sel_rd(sel_rd), .div_rd(div_rd),
        .sw_fail(sw_fail), .sys_ce(sys_ce)
    );

    always #(CLK_P/2) clk = ~clk;

    // Records one comparison.
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int idx_of(input int c);
        return (c == 7) ? 4 : c;
    endfunction

    task automatic do_reset(input logic boot);
        @(negedge clk);
        rst_n = 1'b0; boot_hirc = boot;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 sel", int'(sel_rd), boot ? 7 : 0);
        check("R1 fail", int'(sw_fail), 0);
        check("R1 div", int'(div_rd), 0);
        check("R1 ce", int'(sys_ce), 0);
        rst_n = 1'b1;
    endtask

    task automatic request(input int code);
        sel_wr = 1'b1; sel_wdata = 3'(code);
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    initial begin
        int cur;
        do_reset(1'b1);
        do_reset(1'b0);
        cur = 0;

        // R2 R3 R4 R5: every code against every stable mask.
        for (int m = 0; m < 32; m++) begin
            for (int c = 0; c < 8; c++) begin
                bit ok;
                src_stable = 5'(m);
                ok = (c < 4 || c == 7) && m[idx_of(c)];
                request(c);
                if (ok) cur = c;
                check(ok ? "R3 sel" : (c < 4 || c == 7) ? "R4 sel" : "R5 sel",
                      int'(sel_rd), cur);
                check(ok ? "R3 fail" : "R2 R4 R5 fail", int'(sw_fail), ok ? 0 : 1);
            end
        end

        // R6: clear with 0, clear with 1, clear colliding with a rejected request.
        src_stable = 5'b00000;
        request(1);
        clr_wr = 1'b1; clr_wdata = 1'b0;
        @(negedge clk); clr_wr = 1'b0;
        check("R6 write0 ignored", int'(sw_fail), 1);
        clr_wr = 1'b1; clr_wdata = 1'b1;
        @(negedge clk); clr_wr = 1'b0;
        check("R6 write1 clears", int'(sw_fail), 0);
        clr_wr = 1'b1; clr_wdata = 1'b1;
        request(2);
        clr_wr = 1'b0;
        check("R6 request wins", int'(sw_fail), 1);

        // R7 R8 R9: every source and divide number; selected ticks every third cycle.
        src_stable = 5'b11111;
        for (int c = 0; c < 8; c++) begin
            if (!(c < 4 || c == 7)) continue;
            request(c);
            for (int n = 0; n < 16; n++) begin
                int pulses;
                src_tick = '0;
                div_wr = 1'b1; div_wdata = 4'(n);
                @(negedge clk);
                div_wr = 1'b0;
                check("R9 div readback", int'(div_rd), n);
                check("R8 blank after restart", int'(sys_ce), 0);
                pulses = 0;
                for (int k = 0; k < 48; k++) begin
                    if (k > 0) pulses += int'(sys_ce);
                    src_tick = 5'b11111;
                    src_tick[idx_of(c)] = (k % 3 == 0);
                    @(negedge clk);
                end
                pulses += int'(sys_ce);
                src_tick = '0;
                check("R7 R2 pulse count", pulses, 16 / (n + 1));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule